// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return

This block is the instruction-address unit of a small 4-bit controller. It keeps a 12-bit program counter `P` and two 12-bit save registers, `SA` and `SB`, which together act as a return stack two entries deep. Sequential advance changes only the low six bits of `P`. Execution therefore wraps inside a 64-word page and never crosses into the next page by itself. Only an explicit jump or a return moves `P` to another page.

The opcode decoder presents one decoded operation per cycle on `op_sel`, qualified by `op_valid`. The operation comes with up to two immediate fields. `op_imm_a` carries the low bits of the first instruction byte and `op_imm_b` carries the whole second byte. The unit applies sequential steps, in-page jumps, long jumps, long calls, pointer calls, returns, a save-register swap and a nibble rotate between `SA` and the accumulator. A pointer call reads a byte from a fixed table page through a request/data pair whose data comes back one cycle later. It then jumps into a fixed subroutine page.

The control is a two-state machine. In `ST_RUN` the unit accepts operations and `op_ready` is high. The transition `RUN_TO_WAIT` is taken when a pointer call is accepted. In `ST_PTR_WAIT` the unit ignores `op_valid` and loads `P` from the returned pointer byte. It then always takes `WAIT_TO_RUN` back to `ST_RUN`.

Top module: `paged_pc_unit`

## Requirements
- R1: After reset `pc`, `sa` and `sb` are all zero, `op_ready` is 1, and `ptr_req` and `acc_we` are 0.
- R2: An accepted step operation adds a fixed amount to `pc[5:0]` modulo 64 and leaves `pc[11:6]` unchanged. The amount is 1 for code 0 and 2 for code 1, so 0x03F + 1 gives 0x000 and 0x03F + 2 gives 0x001.
- R3: An accepted short jump (code 2) replaces `pc[5:0]` with `op_imm_a` and keeps `pc[11:6]`. `sa` and `sb` are unchanged.
- R4: An accepted long jump (code 3) loads `pc` with `{op_imm_a[3:0], op_imm_b}`. `sa` and `sb` are unchanged.
- R5: An accepted long call (code 4) moves `sa` into `sb`. It loads `sa` with `pc` plus 2 in the low six bits, wrapping within the page. It loads `pc` as a long jump does.
- R6: An accepted pointer call (code 5) raises `ptr_req` in the same cycle, with `ptr_addr = {6'b000011, op_imm_a}`. It pushes as a long call does, but the saved address is `pc` plus 1 in the low six bits. `op_ready` is then 0 for exactly one cycle. At the end of that cycle `pc` becomes `{4'b0001, ptr_data}`.
- R7: An accepted return (code 6) loads `pc` from `sa` and exchanges `sa` and `sb`.
- R8: An accepted return-and-skip (code 7) behaves like a return, except that `pc` receives `sa` plus 1 in the low six bits, wrapping within the page.
- R9: An accepted swap (code 8) exchanges `sa` and `sb` and steps `pc` by 1.
- R10: An accepted rotate (code 9) raises `acc_we` in the same cycle, with `acc_out = ~sa[3:0]`. At the clock edge `sa` becomes `{~acc_in, sa[11:4]}` and `pc` steps by 1. `sb` is unchanged.
- R11: `pc`, `sa` and `sb` keep their values when no operation is accepted. This covers `op_valid` low, the unused codes 10 to 15, and any operation presented while `op_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded operation is presented |
| op_sel | input | 4 | Operation code (0 to 9 used) |
| op_imm_a | input | 6 | Low bits of the first instruction byte |
| op_imm_b | input | 8 | Second instruction byte |
| acc_in | input | 4 | Current accumulator value |
| ptr_data | input | 8 | Pointer byte, valid one cycle after `ptr_req` |
| op_ready | output | 1 | Unit accepts an operation this cycle |
| pc | output | 12 | Program counter |
| sa | output | 12 | First save register |
| sb | output | 12 | Second save register |
| ptr_req | output | 1 | Pointer table read request |
| ptr_addr | output | 12 | Pointer table address |
| acc_we | output | 1 | Accumulator write strobe for the rotate |
| acc_out | output | 4 | New accumulator value for the rotate |

## Verification
The bench aims at the page boundary. It runs steps, calls and return-and-skip from offset 0x3E and 0x3F. A design that carries into `pc[6]` would move to the next page there, and one that saves the call address without counting the call's length would return onto the second word of the call. It also issues a pointer call with an operation held on the inputs during the wait cycle. A design that does not stall would execute that operation or take the pointer one cycle early. Rotates with fixed patterns show any missing inversion, or a nibble shifted the wrong way, in both `acc_out` and `sa`.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;

    typedef enum logic [3:0] {
        OP_STEP1     = 4'd0,
        OP_STEP2     = 4'd1,
        OP_JMP_PAGE  = 4'd2,
        OP_JMP_FAR   = 4'd3,
        OP_CALL_FAR  = 4'd4,
        OP_CALL_PTR  = 4'd5,
        OP_RET       = 4'd6,
        OP_RET_SKIP  = 4'd7,
        OP_SWAP      = 4'd8,
        OP_ROTATE    = 4'd9
    } pc_op_e;

    typedef enum logic {
        ST_RUN      = 1'b0,
        ST_PTR_WAIT = 1'b1
    } pc_state_e;

endpackage

// File: rtl/page_step.sv
module page_step #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 6,
    parameter int STEP   = 1
) (
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] sum
);
    localparam int HI_W = ADDR_W - OFS_W;
    localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);

    logic [OFS_W-1:0] low_sum;

    always_comb begin
        low_sum = base[OFS_W-1:0] + STEP_V;
        sum     = {base[ADDR_W-1 -: HI_W], low_sum};
    end
endmodule

// File: rtl/link_pair.sv
module link_pair #(
    parameter int ADDR_W = 12,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_val,
    input  logic              swap_en,
    input  logic              rot_en,
    input  logic [NIB_W-1:0]  rot_nib,
    output logic [ADDR_W-1:0] sa_q,
    output logic [ADDR_W-1:0] sb_q
);
    logic [ADDR_W-1:0] sa_d, sb_d;

    always_comb begin
        sa_d = sa_q;
        sb_d = sb_q;
        if (push_en) begin
            sb_d = sa_q;
            sa_d = push_val;
        end else if (swap_en) begin
            sa_d = sb_q;
            sb_d = sa_q;
        end else if (rot_en) begin
            sa_d = {~rot_nib, sa_q[ADDR_W-1:NIB_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q <= '0;
            sb_q <= '0;
        end else begin
            sa_q <= sa_d;
            sb_q <= sb_d;
        end
    end

    // R5
    push_moves_sa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (sb_q == $past(sa_q)) && (sa_q == $past(push_val)));

    // R7
    swap_exchanges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && !push_en) |=> (sa_q == $past(sb_q)) && (sb_q == $past(sa_q)));

    // R10
    rotate_keeps_sb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_en && !push_en && !swap_en) |=> $stable(sb_q));
endmodule

// File: rtl/pc_ctrl.sv
module pc_ctrl
    import paged_pc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int OFS_W       = 6,
    parameter int BYTE_W      = 8,
    parameter int FAR_HI_W    = 4,
    parameter int PTR_PAGE    = 3,
    parameter int SUB_PAGE_HI = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [OFS_W-1:0]  op_imm_a,
    input  logic [BYTE_W-1:0] op_imm_b,
    input  logic [BYTE_W-1:0] ptr_data,
    input  logic [ADDR_W-1:0] pc_inc1,
    input  logic [ADDR_W-1:0] pc_inc2,
    input  logic [ADDR_W-1:0] sa_q,
    input  logic [ADDR_W-1:0] sa_inc1,
    output logic [ADDR_W-1:0] pc_q,
    output logic              op_ready,
    output logic              ptr_req,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              push_en,
    output logic [ADDR_W-1:0] push_val,
    output logic              swap_en,
    output logic              rot_en
);
    localparam int HI_W = ADDR_W - OFS_W;
    localparam logic [HI_W-1:0]     PTR_HI = HI_W'(PTR_PAGE);
    localparam logic [FAR_HI_W-1:0] SUB_HI = FAR_HI_W'(SUB_PAGE_HI);

    pc_state_e         state_q, state_d;
    pc_op_e            op;
    logic              accept;
    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] far_target;

    always_comb begin
        op         = pc_op_e'(op_sel);
        accept     = op_valid && (state_q == ST_RUN);
        far_target = {op_imm_a[FAR_HI_W-1:0], op_imm_b};
        op_ready   = (state_q == ST_RUN);
        ptr_addr   = {PTR_HI, op_imm_a};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (accept && op == OP_CALL_PTR) state_d = ST_PTR_WAIT;
            ST_PTR_WAIT: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // outputs and datapath control
    always_comb begin
        pc_d     = pc_q;
        push_en  = 1'b0;
        push_val = pc_inc1;
        swap_en  = 1'b0;
        rot_en   = 1'b0;
        ptr_req  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (op_valid) begin
                    case (op)
                        OP_STEP1:    pc_d = pc_inc1;
                        OP_STEP2:    pc_d = pc_inc2;
                        OP_JMP_PAGE: pc_d = {pc_q[ADDR_W-1 -: HI_W], op_imm_a};
                        OP_JMP_FAR:  pc_d = far_target;
                        OP_CALL_FAR: begin
                            push_en  = 1'b1;
                            push_val = pc_inc2;
                            pc_d     = far_target;
                        end
                        OP_CALL_PTR: begin
                            push_en  = 1'b1;
                            push_val = pc_inc1;
                            ptr_req  = 1'b1;
                        end
                        OP_RET: begin
                            swap_en = 1'b1;
                            pc_d    = sa_q;
                        end
                        OP_RET_SKIP: begin
                            swap_en = 1'b1;
                            pc_d    = sa_inc1;
                        end
                        OP_SWAP: begin
                            swap_en = 1'b1;
                            pc_d    = pc_inc1;
                        end
                        OP_ROTATE: begin
                            rot_en = 1'b1;
                            pc_d   = pc_inc1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PTR_WAIT: pc_d = {SUB_HI, ptr_data};
            default: ;
        endcase
    end

    // R11
    idle_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && !op_valid) |=> $stable(pc_q));

    // R6
    ptr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req |=> !op_ready ##1 op_ready);

    // R6
    ptr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready |=> pc_q[ADDR_W-1 -: FAR_HI_W] == SUB_HI);

    // R2
    step_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_STEP1 || op == OP_STEP2))
            |=> pc_q[ADDR_W-1 -: HI_W] == $past(pc_q[ADDR_W-1 -: HI_W]));

    // R7
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_RET) |=> pc_q == $past(sa_q));
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
    import paged_pc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int OFS_W       = 6,
    parameter int BYTE_W      = 8,
    parameter int NIB_W       = 4,
    parameter int PTR_PAGE    = 3,
    parameter int SUB_PAGE_HI = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [OFS_W-1:0]  op_imm_a,
    input  logic [BYTE_W-1:0] op_imm_b,
    input  logic [NIB_W-1:0]  acc_in,
    input  logic [BYTE_W-1:0] ptr_data,
    output logic              op_ready,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sa,
    output logic [ADDR_W-1:0] sb,
    output logic              ptr_req,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              acc_we,
    output logic [NIB_W-1:0]  acc_out
);
    localparam int FAR_HI_W = ADDR_W - BYTE_W;
    localparam int N_STEPS  = 2;

    logic [ADDR_W-1:0] pc_step [N_STEPS];
    logic [ADDR_W-1:0] sa_inc1;
    logic              push_en, swap_en, rot_en;
    logic [ADDR_W-1:0] push_val;

    for (genvar k = 0; k < N_STEPS; k++) begin : g_pc_step
        page_step #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .STEP(k + 1)) u_step (
            .base(pc),
            .sum (pc_step[k])
        );
    end

    page_step #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .STEP(1)) u_sa_step (
        .base(sa),
        .sum (sa_inc1)
    );

    pc_ctrl #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W), .FAR_HI_W(FAR_HI_W),
        .PTR_PAGE(PTR_PAGE), .SUB_PAGE_HI(SUB_PAGE_HI)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_valid(op_valid),
        .op_sel  (op_sel),
        .op_imm_a(op_imm_a),
        .op_imm_b(op_imm_b),
        .ptr_data(ptr_data),
        .pc_inc1 (pc_step[0]),
        .pc_inc2 (pc_step[1]),
        .sa_q    (sa),
        .sa_inc1 (sa_inc1),
        .pc_q    (pc),
        .op_ready(op_ready),
        .ptr_req (ptr_req),
        .ptr_addr(ptr_addr),
        .push_en (push_en),
        .push_val(push_val),
        .swap_en (swap_en),
        .rot_en  (rot_en)
    );

    link_pair #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_en (push_en),
        .push_val(push_val),
        .swap_en (swap_en),
        .rot_en  (rot_en),
        .rot_nib (acc_in),
        .sa_q    (sa),
        .sb_q    (sb)
    );

    always_comb begin
        acc_we  = rot_en;
        acc_out = ~sa[NIB_W-1:0];
    end

    // R10
    rotate_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> sa[ADDR_W-1 -: NIB_W] == ~$past(acc_in));
endmodule

// File: tb/paged_pc_unit_tb_top.sv
module paged_pc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [5:0]  op_imm_a = '0;
    logic [7:0]  op_imm_b = '0;
    logic [3:0]  acc_in = '0;
    logic [7:0]  ptr_data = '0;
    logic        op_ready, ptr_req, acc_we;
    logic [11:0] pc, sa, sb, ptr_addr;
    logic [3:0]  acc_out;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_pc, m_sa, m_sb;

    always #10 clk = ~clk;

    paged_pc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .op_imm_a(op_imm_a), .op_imm_b(op_imm_b), .acc_in(acc_in),
        .ptr_data(ptr_data), .op_ready(op_ready), .pc(pc), .sa(sa), .sb(sb),
        .ptr_req(ptr_req), .ptr_addr(ptr_addr), .acc_we(acc_we), .acc_out(acc_out)
    );

    function automatic logic [7:0] tbl(input logic [11:0] a);
        return a[7:0] * 8'd37 + 8'h1B;
    endfunction

    always @(posedge clk) if (ptr_req) ptr_data <= tbl(ptr_addr);

    function automatic logic [11:0] inc_pg(input logic [11:0] a, input int k);
        logic [5:0] lo;
        lo = a[5:0] + 6'(k);
        return {a[11:6], lo};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic v);
        if (!v || op > 4'd9) return "R11";
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "pc", pc, m_pc);
        chk(req, "sa", sa, m_sa);
        chk(req, "sb", sb, m_sb);
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic run_op(input logic v, input logic [3:0] op, input logic [5:0] a,
                          input logic [7:0] b, input logic [3:0] acc);
        string req;
        logic [11:0] t;
        logic [7:0] pdat;
        req = tag_of(op, v);
        op_valid = v; op_sel = op; op_imm_a = a; op_imm_b = b; acc_in = acc;
        #1;
        if (v && op == 4'd9) begin
            chk("R10", "acc_we", {11'd0, acc_we}, 12'd1);
            chk("R10", "acc_out", {8'd0, acc_out}, {8'd0, ~m_sa[3:0]});
        end
        if (v && op == 4'd5) begin
            chk("R6", "ptr_req", {11'd0, ptr_req}, 12'd1);
            chk("R6", "ptr_addr", ptr_addr, {6'b000011, a});
        end
        pdat = tbl({6'b000011, a});
        if (v) begin
            case (op)
                4'd0: m_pc = inc_pg(m_pc, 1);
                4'd1: m_pc = inc_pg(m_pc, 2);
                4'd2: m_pc = {m_pc[11:6], a};
                4'd3: m_pc = {a[3:0], b};
                4'd4: begin m_sb = m_sa; m_sa = inc_pg(m_pc, 2); m_pc = {a[3:0], b}; end
                4'd5: begin m_sb = m_sa; m_sa = inc_pg(m_pc, 1); end
                4'd6: begin m_pc = m_sa; t = m_sa; m_sa = m_sb; m_sb = t; end
                4'd7: begin m_pc = inc_pg(m_sa, 1); t = m_sa; m_sa = m_sb; m_sb = t; end
                4'd8: begin t = m_sa; m_sa = m_sb; m_sb = t; m_pc = inc_pg(m_pc, 1); end
                4'd9: begin m_sa = {~acc, m_sa[11:4]}; m_pc = inc_pg(m_pc, 1); end
                default: ;
            endcase
        end
        @(posedge clk); @(negedge clk);
        if (v && op == 4'd5) begin
            chk("R6", "op_ready low", {11'd0, op_ready}, 12'd0);
            check_state("R6");
            // operation held during the wait must be ignored
            op_valid = 1'b1; op_sel = 4'd3; op_imm_a = 6'h2A; op_imm_b = 8'h77;
            m_pc = {4'b0001, pdat};
            @(posedge clk); @(negedge clk);
            chk("R6", "op_ready back", {11'd0, op_ready}, 12'd1);
            check_state("R6");
            op_valid = 1'b0;
        end else begin
            check_state(req);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        m_pc = '0; m_sa = '0; m_sb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_state("R1");
        chk("R1", "op_ready", {11'd0, op_ready}, 12'd1);
        chk("R1", "ptr_req", {11'd0, ptr_req}, 12'd0);
        chk("R1", "acc_we", {11'd0, acc_we}, 12'd0);

        // Directed page-boundary cases
        run_op(1, 4'd3, 6'h05, 8'h3F, 4'h0);   // R4: pc = 0x53F
        run_op(1, 4'd0, 6'h00, 8'h00, 4'h0);   // R2: wrap to 0x500
        run_op(1, 4'd2, 6'h3E, 8'h00, 4'h0);   // R3: 0x53E
        run_op(1, 4'd1, 6'h00, 8'h00, 4'h0);   // R2: 0x540? no, wraps to 0x500
        run_op(1, 4'd2, 6'h3F, 8'h00, 4'h0);   // R3
        run_op(1, 4'd1, 6'h00, 8'h00, 4'h0);   // R2: 0x501
        run_op(1, 4'd2, 6'h3E, 8'h00, 4'h0);
        run_op(1, 4'd4, 6'h09, 8'h10, 4'h0);   // R5: return addr wraps to 0x500
        run_op(1, 4'd2, 6'h3F, 8'h00, 4'h0);
        run_op(1, 4'd5, 6'h2D, 8'h00, 4'h0);   // R6
        run_op(1, 4'd7, 6'h00, 8'h00, 4'h0);   // R8: sa low 0x00+1
        run_op(1, 4'd7, 6'h00, 8'h00, 4'h0);   // R8 again on other entry
        run_op(1, 4'd8, 6'h00, 8'h00, 4'h0);   // R9
        run_op(1, 4'd9, 6'h00, 8'h00, 4'hA);   // R10
        run_op(1, 4'd9, 6'h00, 8'h00, 4'h3);   // R10
        run_op(1, 4'd6, 6'h00, 8'h00, 4'h0);   // R7
        run_op(0, 4'd3, 6'h11, 8'h22, 4'h0);   // R11 invalid
        run_op(1, 4'd12, 6'h11, 8'h22, 4'h0);  // R11 unused code

        // Constrained random traffic
        for (int i = 0; i < 600; i++) begin
            logic v;
            logic [3:0] op;
            v  = ($urandom % 10) != 0;
            op = 4'($urandom % 12);
            run_op(v, op, 6'($urandom), 8'($urandom), 4'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule